// File: doc/BRIEF.md
# Memory Strobe Decoder for Internal and External Memory

The decoder sits between a processor's 16-bit code and data address space and the memories behind it. It watches three one-cycle access requests (program fetch, data read, data write) and the address, then routes each access to one of three targets: a 16 KB internal RAM at the bottom of the space, a 512-byte internal scratch-pad placed at a parameterized base above 16 KB, or the external memory bus. Any address the chip implements internally never produces an external strobe. A full 64 KB external memory can therefore hang on the bus without any address decoding of its own.

An external-access mode pin picks the code mapping. With the pin low, the internal RAM serves both program fetches and data reads through one internal read strobe. With the pin high, program fetches to the bottom 16 KB go to the external bus, and the internal RAM is then reached only by data accesses. The pin is captured while reset is held, and the captured value holds until the next reset.

All strobes and the per-target addresses come out of registers. Every output therefore changes on the same clock edge, one cycle after the request.

Top module: `memStrobeDecoder`

## Requirements
- R1: While reset is held, and on the first sample after it, all six strobe outputs are 0.
- R2: The mode is the value of `extAccessPin` during reset. Changes to the pin after reset release have no effect on routing until the next reset.
- R3: With the mode at 0, a program fetch to an address below 16384 asserts `ramRd` alone.
- R4: With the mode at 1, a program fetch to an address below 16384 asserts `extRd` alone, and `ramRd` stays 0.
- R5: In either mode, a data read or data write to an address below 16384 asserts `ramRd` or `ramWr` alone.
- R6: Any access to an address in the window from PAD_BASE (default 0xE000) to PAD_BASE+511 asserts `padRd` (fetch or data read) or `padWr` (data write) alone, and never an external strobe.
- R7: Any access to an address outside both internal regions asserts `extRd` (fetch or data read) or `extWr` (data write) alone.
- R8: A program fetch never produces a write strobe on any target. Only a data write does.
- R9: Strobes appear exactly one clock after the request. In the same cycle `ramAddr` equals address bits [13:0], `padAddr` equals address minus PAD_BASE in 9 bits, and `extAddr` equals the full address.
- R10: At most one strobe is high in any cycle. With several requests at once, fetch wins over data read, and data read wins over data write. With no request, no strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; asynchronous for the strobes; the mode is captured on clock edges while it is low |
| extAccessPin | input | 1 | Code mapping select: 1 sends low code space to the external bus |
| codeFetch | input | 1 | Program fetch request, active high |
| dataRead | input | 1 | Data read request, active high |
| dataWrite | input | 1 | Data write request, active high |
| addr | input | 16 | Access address |
| ramRd | output | 1 | Internal RAM read strobe |
| ramWr | output | 1 | Internal RAM write strobe |
| ramAddr | output | 14 | Internal RAM word address |
| padRd | output | 1 | Scratch-pad read strobe |
| padWr | output | 1 | Scratch-pad write strobe |
| padAddr | output | 9 | Scratch-pad offset address |
| extRd | output | 1 | External bus read strobe |
| extWr | output | 1 | External bus write strobe |
| extAddr | output | 16 | External bus address |

## Verification
A wrong captured mode shows up one cycle after the first low-space fetch, as `extRd` where `ramRd` was due or the reverse. This is why the sweep runs in both modes with the pin flipped right after reset. A wrong region boundary or priority shows at the ports on the very next clock: the strobe lands on the wrong target, or an external strobe leaks out for an internal address. The sweep therefore covers every region edge and each request combination. An address register that misses its update shows up in the same cycle as the strobe it belongs to.

// File: rtl/memDecPkg.sv
package memDecPkg;

  typedef struct packed {
    logic ramRd;
    logic ramWr;
    logic padRd;
    logic padWr;
    logic extRd;
    logic extWr;
  } strobe_t;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_FETCH = 2'd1,
    ACC_READ  = 2'd2,
    ACC_WRITE = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    REG_RAM = 2'd0,
    REG_PAD = 2'd1,
    REG_EXT = 2'd2
  } region_e;

endpackage

// File: rtl/memDecRegion.sv
module memDecRegion
  import memDecPkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned RAM_BYTES = 16384,
  parameter int unsigned PAD_BASE  = 32'h0000_E000,
  parameter int unsigned PAD_BYTES = 512
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam int unsigned PAD_END = PAD_BASE + PAD_BYTES;

  logic [31:0] addrWide;
  logic        hitRam;
  logic        hitPad;

  assign addrWide = 32'(addr);
  assign hitRam   = addrWide < RAM_BYTES;
  assign hitPad   = (addrWide >= PAD_BASE) && (addrWide < PAD_END);

  always_comb begin
    if (hitRam)      region = REG_RAM;
    else if (hitPad) region = REG_PAD;
    else             region = REG_EXT;
  end
endmodule

// File: rtl/memDecCtrl.sv
module memDecCtrl
  import memDecPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    extAccessPin,
  input  logic    codeFetch,
  input  logic    dataRead,
  input  logic    dataWrite,
  input  region_e region,
  output strobe_t nextStb,
  output logic    extMode
);
  logic extModeQ;
  acc_e accKind;

  // Mode capture: follows the pin only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) extModeQ <= extAccessPin;
  end
  assign extMode = extModeQ;

  // Request priority: fetch, then read, then write
  always_comb begin
    if (codeFetch)      accKind = ACC_FETCH;
    else if (dataRead)  accKind = ACC_READ;
    else if (dataWrite) accKind = ACC_WRITE;
    else                accKind = ACC_NONE;
  end

  always_comb begin
    nextStb = '0;
    unique case (accKind)
      ACC_FETCH: begin
        unique case (region)
          REG_RAM: begin
            if (extModeQ) nextStb.extRd = 1'b1;
            else          nextStb.ramRd = 1'b1;
          end
          REG_PAD: nextStb.padRd = 1'b1;
          default: nextStb.extRd = 1'b1;
        endcase
      end
      ACC_READ: begin
        unique case (region)
          REG_RAM: nextStb.ramRd = 1'b1;
          REG_PAD: nextStb.padRd = 1'b1;
          default: nextStb.extRd = 1'b1;
        endcase
      end
      ACC_WRITE: begin
        unique case (region)
          REG_RAM: nextStb.ramWr = 1'b1;
          REG_PAD: nextStb.padWr = 1'b1;
          default: nextStb.extWr = 1'b1;
        endcase
      end
      default: nextStb = '0;
    endcase
  end

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(extModeQ))
    else $error("mode changed after reset release");

endmodule

// File: rtl/memDecPath.sv
module memDecPath
  import memDecPkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned RAM_BYTES = 16384,
  parameter int unsigned PAD_BASE  = 32'h0000_E000,
  parameter int unsigned PAD_BYTES = 512
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  nextStb,
  input  logic [ADDR_W-1:0]        addr,
  output strobe_t                  stbQ,
  output logic [$clog2(RAM_BYTES)-1:0] ramAddr,
  output logic [$clog2(PAD_BYTES)-1:0] padAddr,
  output logic [ADDR_W-1:0]        extAddr
);
  localparam int unsigned RAM_AW  = $clog2(RAM_BYTES);
  localparam int unsigned PAD_AW  = $clog2(PAD_BYTES);
  localparam int unsigned PAD_END = PAD_BASE + PAD_BYTES;

  logic              anyStb;
  logic [ADDR_W-1:0] padOff;

  assign anyStb = |nextStb;
  assign padOff = addr - ADDR_W'(PAD_BASE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stbQ <= '0;
    else       stbQ <= nextStb;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramAddr <= '0;
      padAddr <= '0;
      extAddr <= '0;
    end else if (anyStb) begin
      ramAddr <= addr[RAM_AW-1:0];
      padAddr <= padOff[PAD_AW-1:0];
      extAddr <= addr;
    end
  end

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stbQ))
    else $error("more than one strobe active");

  p_ext_not_pad_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stbQ.extRd || stbQ.extWr) |->
      !((32'(extAddr) >= PAD_BASE) && (32'(extAddr) < PAD_END)))
    else $error("external strobe for scratch-pad address");

  p_ext_wr_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    stbQ.extWr |-> (32'(extAddr) >= RAM_BYTES))
    else $error("external write inside internal RAM space");

endmodule

// File: rtl/memStrobeDecoder.sv
module memStrobeDecoder
  import memDecPkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned RAM_BYTES = 16384,
  parameter int unsigned PAD_BASE  = 32'h0000_E000,
  parameter int unsigned PAD_BYTES = 512,
  localparam int unsigned RAM_AW   = $clog2(RAM_BYTES),
  localparam int unsigned PAD_AW   = $clog2(PAD_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extAccessPin,
  input  logic              codeFetch,
  input  logic              dataRead,
  input  logic              dataWrite,
  input  logic [ADDR_W-1:0] addr,
  output logic              ramRd,
  output logic              ramWr,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              padRd,
  output logic              padWr,
  output logic [PAD_AW-1:0] padAddr,
  output logic              extRd,
  output logic              extWr,
  output logic [ADDR_W-1:0] extAddr
);
  region_e region;
  strobe_t nextStb;
  strobe_t stbQ;
  logic    extMode;
  logic    lowAddr;

  memDecRegion #(
    .ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES),
    .PAD_BASE(PAD_BASE), .PAD_BYTES(PAD_BYTES)
  ) u_region (
    .addr  (addr),
    .region(region)
  );

  memDecCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .extAccessPin(extAccessPin),
    .codeFetch   (codeFetch),
    .dataRead    (dataRead),
    .dataWrite   (dataWrite),
    .region      (region),
    .nextStb     (nextStb),
    .extMode     (extMode)
  );

  memDecPath #(
    .ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES),
    .PAD_BASE(PAD_BASE), .PAD_BYTES(PAD_BYTES)
  ) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .nextStb(nextStb),
    .addr   (addr),
    .stbQ   (stbQ),
    .ramAddr(ramAddr),
    .padAddr(padAddr),
    .extAddr(extAddr)
  );

  assign ramRd = stbQ.ramRd;
  assign ramWr = stbQ.ramWr;
  assign padRd = stbQ.padRd;
  assign padWr = stbQ.padWr;
  assign extRd = stbQ.extRd;
  assign extWr = stbQ.extWr;

  assign lowAddr = 32'(addr) < RAM_BYTES;

  p_fetch_nowrite_r8: assert property (@(posedge clk) disable iff (!rstN)
    codeFetch |=> !(ramWr || padWr || extWr))
    else $error("fetch produced a write");

  p_low_fetch_int_r3: assert property (@(posedge clk) disable iff (!rstN)
    (codeFetch && lowAddr && !extMode) |=> (ramRd && !extRd))
    else $error("low fetch missed internal RAM");

  p_low_fetch_ext_r4: assert property (@(posedge clk) disable iff (!rstN)
    (codeFetch && lowAddr && extMode) |=> (extRd && !ramRd))
    else $error("low fetch missed external bus");

  p_low_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrite && !codeFetch && !dataRead && lowAddr) |=> (ramWr && !extWr))
    else $error("low write missed internal RAM");

endmodule

// File: tb/memStrobeDecoder_bench.sv
`timescale 1ns/1ps
module memStrobeDecoder_bench;
  localparam int unsigned RAM_B   = 16384;
  localparam int unsigned PAD_B   = 32'h0000_E000;
  localparam int unsigned PAD_N   = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extAccessPin = 1'b0;
  logic        codeFetch = 1'b0;
  logic        dataRead = 1'b0;
  logic        dataWrite = 1'b0;
  logic [15:0] addr = '0;
  logic        ramRd, ramWr, padRd, padWr, extRd, extWr;
  logic [13:0] ramAddr;
  logic [8:0]  padAddr;
  logic [15:0] extAddr;

  int checks = 0;
  int fails = 0;
  logic benchMode = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  memStrobeDecoder u_memStrobeDecoder (
    .clk(clk), .rstN(rstN), .extAccessPin(extAccessPin),
    .codeFetch(codeFetch), .dataRead(dataRead), .dataWrite(dataWrite),
    .addr(addr), .ramRd(ramRd), .ramWr(ramWr), .ramAddr(ramAddr),
    .padRd(padRd), .padWr(padWr), .padAddr(padAddr),
    .extRd(extRd), .extWr(extWr), .extAddr(extAddr)
  );

  function automatic logic [5:0] outVec();
    return {ramRd, ramWr, padRd, padWr, extRd, extWr};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, act, exp);
    end
  endtask

  task automatic doReset(input logic mode);
    rstN = 1'b0;
    extAccessPin = mode;
    codeFetch = 1'b0; dataRead = 1'b0; dataWrite = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 strobes in reset", 32'(outVec()), 32'd0);
    rstN = 1'b1;
    benchMode = mode;
    @(negedge clk);
    check("R1 strobes after reset", 32'(outVec()), 32'd0);
    extAccessPin = ~mode; // R2: pin flips after release, must be ignored
  endtask

  // bit order {ramRd,ramWr,padRd,padWr,extRd,extWr}
  task automatic access(input logic f, input logic r, input logic w,
                        input logic [15:0] a, input string force_tag);
    int unsigned aw;
    logic [5:0] exp;
    string tag;
    int kind;
    int reg_;
    codeFetch = f; dataRead = r; dataWrite = w; addr = a;
    aw = 32'(a);
    kind = f ? 1 : (r ? 2 : (w ? 3 : 0));
    reg_ = (aw < RAM_B) ? 0 : ((aw >= PAD_B && aw < PAD_B + PAD_N) ? 1 : 2);
    exp = '0;
    tag = "R7";
    if (kind == 1) begin
      if (reg_ == 0) begin
        if (benchMode) begin exp = 6'b000010; tag = "R4"; end
        else begin exp = 6'b100000; tag = "R3"; end
      end else if (reg_ == 1) begin exp = 6'b001000; tag = "R6"; end
      else exp = 6'b000010;
    end else if (kind == 2) begin
      if (reg_ == 0) begin exp = 6'b100000; tag = "R5"; end
      else if (reg_ == 1) begin exp = 6'b001000; tag = "R6"; end
      else exp = 6'b000010;
    end else if (kind == 3) begin
      if (reg_ == 0) begin exp = 6'b010000; tag = "R5"; end
      else if (reg_ == 1) begin exp = 6'b000100; tag = "R6"; end
      else exp = 6'b000001;
    end else tag = "R10";
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    check(tag, 32'(outVec()), 32'(exp));
    if (kind == 1)
      check("R8 fetch no write", 32'({ramWr, padWr, extWr}), 32'd0);
    if (kind != 0) begin
      if (reg_ == 0) check("R9 ramAddr", 32'(ramAddr), aw % RAM_B);
      else if (reg_ == 1) check("R9 padAddr", 32'(padAddr), aw - PAD_B);
      check("R9 extAddr", 32'(extAddr), aw);
    end
  endtask

  task automatic sweep();
    int unsigned edges[10] = '{0, 1, RAM_B - 1, RAM_B, PAD_B - 1, PAD_B,
                               PAD_B + PAD_N - 1, PAD_B + PAD_N, 32'h8000, 32'hFFFF};
    foreach (edges[i]) begin
      access(1, 0, 0, 16'(edges[i]), "");
      access(0, 1, 0, 16'(edges[i]), "");
      access(0, 0, 1, 16'(edges[i]), "");
    end
    for (int a = 0; a < 65536; a += 37) begin
      access(1, 0, 0, 16'(a), "");
      access(0, 1, 0, 16'(a), "");
      access(0, 0, 1, 16'(a), "");
      access(0, 0, 0, 16'(a), "R10 idle");
    end
  endtask

  task automatic combos();
    int unsigned pts[3] = '{32'h0100, PAD_B + 4, 32'h9000};
    foreach (pts[i]) begin
      access(1, 1, 1, 16'(pts[i]), "R10 all three");
      access(1, 0, 1, 16'(pts[i]), "R10 fetch+write");
      access(0, 1, 1, 16'(pts[i]), "R10 read+write");
      access(1, 1, 0, 16'(pts[i]), "R10 fetch+read");
    end
  endtask

  initial begin
    doReset(1'b0);
    access(1, 0, 0, 16'h0000, "R2 mode0 kept");
    sweep();
    combos();
    doReset(1'b1);
    access(1, 0, 0, 16'h0000, "R2 mode1 kept");
    sweep();
    combos();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule